// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block turns one vector memory operation into a stream of per-element effective addresses. A single start pulse captures a base value, a flag that forces the base term to zero, a 16-bit signed displacement, an element size, a requested element count and an addressing mode. The block then presents one element index and one 64-bit address per cycle, under a valid/ready handshake, until the effective count is used up.

There are four addressing modes. Unit-stride places elements back to back after base plus displacement. Element-stride spaces them by the displacement itself. Post-increment uses a running base that moves by the displacement after each element. Bit-reversed ordering walks the elements in a butterfly order. The consumer may cut the vector short with a truncate input. When the sequence ends, the block pulses done and reports the written-back base value. Update forms use that value.

Top module: `vagu_seq`

## Requirements
- R1: When `base_zero` is 1 at start, the base term is 0 and `base_in` has no effect on any address or on `final_base`.
- R2: With `mode` = 0 (unit-stride), element i has address base + sext(disp) + (i << `size_log2`). `size_log2` values 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. `out_idx` = i, and elements come in ascending order.
- R3: With `mode` = 1 (element-stride) and a nonzero displacement, element i has address base + sext(disp) × i. With a zero displacement, mode 1 behaves exactly like mode 0.
- R4: With `mode` = 2 (post-increment), element i has address base + i × sext(disp). `final_base` equals base + n × sext(disp), where n is the number of elements actually issued.
- R5: With `mode` = 3 (bit-reversed), the k-th issued element has index rev(k), the low log2(L) bits of k reversed, where L is the effective length. That index appears on `out_idx`, and the address is base + sext(disp) + (rev(k) << `size_log2`). For L = 4 the order is 0, 2, 1, 3.
- R6: The effective length L is the smaller of `req_len` and the parameter MAX_LEN (default 8).
- R7: If `trunc` is 1 while `out_valid` is 1, the presented element is withdrawn and not counted, whatever `out_ready` is. No further element follows, and done pulses on the next cycle.
- R8: While `out_valid` is 1, `out_ready` is 0 and `trunc` is 0, the next cycle still shows `out_valid` = 1 with the same `out_idx` and `out_addr`.
- R9: `done` is a single-cycle pulse in the cycle after the last element is accepted, with `out_valid` low. `final_base` is valid with it and holds until the next start. For modes 0, 1 and 3, `final_base` equals the base term.
- R10: In mode 3, a nonzero L that is not a power of two issues no element. It raises `err` and pulses `done` in the cycle after start. `err` stays high until the next accepted start.
- R11: An effective length of 0 issues no element and pulses `done` in the cycle after start, with `final_base` equal to the base term and `err` low.
- R12: A start pulse while `out_valid` is 1 is ignored. The running sequence continues unchanged.
- R13: All address and base arithmetic is 64-bit and wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; captures all operation inputs when idle |
| base_in | input | 64 | Base register value |
| base_zero | input | 1 | Use constant zero as the base term |
| disp | input | 16 | Signed displacement |
| size_log2 | input | 2 | Element size as log2 of bytes |
| mode | input | 2 | 0 unit-stride, 1 element-stride, 2 post-increment, 3 bit-reversed |
| req_len | input | 8 | Requested element count |
| trunc | input | 1 | Withdraw the presented element and end the vector |
| out_ready | input | 1 | Consumer accepts the presented element |
| out_valid | output | 1 | An element index and address are presented |
| out_idx | output | 3 | Element index being accessed |
| out_addr | output | 64 | Effective address of that element |
| done | output | 1 | One-cycle end-of-operation pulse |
| final_base | output | 64 | Written-back base value |
| err | output | 1 | Bit-reversed length was not a power of two |

## Verification
The in-design assertions assume that `trunc` is raised only while an element is being presented. They also assume the operation inputs matter only in the cycle that `start` is accepted. The stride and hold properties rely on the consumer leaving `trunc` low whenever it stalls. The bench drives `trunc` only when `out_valid` is high, at a chosen element position. It drives `out_ready` from a pseudo-random pattern or holds it high. It changes the operation inputs mid-run only together with a start pulse that must be ignored.

// File: rtl/vagu_pkg.sv
// Package: shared types for the vector address sequencer.
// Assumes: mode encoding is fixed at the block's ports (2 bits).
package vagu_pkg;

    // Addressing mode; the codes match the values driven on the mode port.
    typedef enum logic [1:0] {
        AM_UNIT    = 2'd0,
        AM_ESTRIDE = 2'd1,
        AM_POSTINC = 2'd2,
        AM_BITREV  = 2'd3
    } addr_mode_e;

endpackage

// File: rtl/vagu_len_ctl.sv
// Module: vagu_len_ctl
// Clamps the requested element count to MAX_LEN and classifies the result:
// zero, power of two, and its base-2 logarithm (valid for powers of two).
// Assumes: MAX_LEN fits in LEN_W bits and in CNT_W bits.
module vagu_len_ctl #(
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 8,
    parameter int CNT_W   = 4,
    parameter int LG_W    = 2
) (
    input  logic [LEN_W-1:0] req_len,
    output logic [CNT_W-1:0] eff_len,
    output logic             is_zero,
    output logic             is_pow2,
    output logic [LG_W-1:0]  lg2
);

    // Clamp the request to the configured maximum.
    always_comb begin
        if (req_len > LEN_W'(MAX_LEN))
            eff_len = CNT_W'(MAX_LEN);
        else
            eff_len = CNT_W'(req_len);
    end

    // Zero and power-of-two classification.
    always_comb begin
        is_zero = (eff_len == '0);
        is_pow2 = !is_zero && ((eff_len & (eff_len - CNT_W'(1))) == '0);
    end

    // Position of the highest set bit, which is log2 for a power of two.
    always_comb begin
        lg2 = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (eff_len[i])
                lg2 = LG_W'(i);
        end
    end

endmodule

// File: rtl/vagu_bitrev.sv
// Module: vagu_bitrev
// Reverses the low 'lg' bits of an element index. The result is a full
// IDX_W-bit reversal shifted down so that only 'lg' bits remain.
// Assumes: idx < 2**lg and lg <= IDX_W.
module vagu_bitrev #(
    parameter int IDX_W = 3,
    parameter int LG_W  = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [LG_W-1:0]  lg,
    output logic [IDX_W-1:0] rev
);

    logic [IDX_W-1:0] full_rev;
    logic [LG_W-1:0]  shamt;

    // Full-width mirror of the index bits.
    for (genvar g = 0; g < IDX_W; g++) begin : g_mirror
        assign full_rev[g] = idx[IDX_W-1-g];
    end

    // Drop the unused high positions so that only lg bits are reversed.
    always_comb begin
        shamt = LG_W'(IDX_W) - lg;
        rev   = full_rev >> shamt;
    end

endmodule

// File: rtl/vagu_addr_gen.sv
// Module: vagu_addr_gen
// Forms the address and index of the presented element from the captured
// operation state. Purely combinational; all sums wrap at AW bits.
// Assumes: element-stride with zero displacement was already remapped to
// unit-stride by the caller.
module vagu_addr_gen
    import vagu_pkg::*;
#(
    parameter int AW    = 64,
    parameter int IDX_W = 3
) (
    input  addr_mode_e       mode,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    dext,
    input  logic [1:0]       size_log2,
    input  logic [IDX_W-1:0] seq_idx,
    input  logic [IDX_W-1:0] rev_idx,
    input  logic [AW-1:0]    run_base,
    output logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] elem_idx
);

    logic [AW-1:0] unit_off;
    logic [AW-1:0] rev_off;

    // Byte offsets for packed elements at sequential or reversed positions.
    always_comb begin
        unit_off = AW'(seq_idx) << size_log2;
        rev_off  = AW'(rev_idx) << size_log2;
    end

    // Mode selection of the address and reported index.
    always_comb begin
        elem_idx = seq_idx;
        unique case (mode)
            AM_UNIT:    addr = base + dext + unit_off;
            AM_ESTRIDE: addr = base + dext * AW'(seq_idx);
            AM_POSTINC: addr = run_base;
            AM_BITREV: begin
                addr     = base + dext + rev_off;
                elem_idx = rev_idx;
            end
            default:    addr = base;
        endcase
    end

endmodule

// File: rtl/vagu_seq.sv
// Module: vagu_seq (top)
// Sequences the elements of one vector load/store. It captures the operation
// on start, presents one index/address per cycle under valid/ready, honours
// truncation, and ends with a done pulse that carries the written-back base.
// Assumes: trunc is raised only while out_valid is high; operation inputs
// matter only in the cycle start is accepted. MAX_LEN >= 2.
module vagu_seq
    import vagu_pkg::*;
#(
    parameter int AW      = 64,
    parameter int DISP_W  = 16,
    parameter int LEN_W   = 8,
    parameter int MAX_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_in,
    input  logic              base_zero,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        size_log2,
    input  logic [1:0]        mode,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              trunc,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [$clog2(MAX_LEN)-1:0] out_idx,
    output logic [AW-1:0]     out_addr,
    output logic              done,
    output logic [AW-1:0]     final_base,
    output logic              err
);

    localparam int CNT_W = $clog2(MAX_LEN + 1);
    localparam int IDX_W = $clog2(MAX_LEN);
    localparam int LG_W  = $clog2(IDX_W + 1);

    // Captured operation state.
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [LG_W-1:0]  lg_q;
    addr_mode_e       mode_q;
    logic [1:0]       sz_q;
    logic [AW-1:0]    base_q;
    logic [AW-1:0]    dext_q;
    logic [AW-1:0]    run_q;
    logic             done_q;
    logic             err_q;
    logic [AW-1:0]    fbase_q;

    // Decoded inputs at start.
    logic [CNT_W-1:0] eff_len;
    logic             len_zero;
    logic             len_pow2;
    logic [LG_W-1:0]  len_lg2;
    logic [AW-1:0]    base_term;
    logic [AW-1:0]    dext_in;
    addr_mode_e       mode_in;
    logic             accept;
    logic             bad_len;

    // Per-element control.
    logic [IDX_W-1:0] rev_idx;
    logic             last_elem;
    logic             fire;
    logic [AW-1:0]    run_next;

    vagu_len_ctl #(
        .LEN_W  (LEN_W),
        .MAX_LEN(MAX_LEN),
        .CNT_W  (CNT_W),
        .LG_W   (LG_W)
    ) u_len (
        .req_len(req_len),
        .eff_len(eff_len),
        .is_zero(len_zero),
        .is_pow2(len_pow2),
        .lg2    (len_lg2)
    );

    vagu_bitrev #(
        .IDX_W(IDX_W),
        .LG_W (LG_W)
    ) u_rev (
        .idx(cnt_q[IDX_W-1:0]),
        .lg (lg_q),
        .rev(rev_idx)
    );

    vagu_addr_gen #(
        .AW   (AW),
        .IDX_W(IDX_W)
    ) u_agen (
        .mode     (mode_q),
        .base     (base_q),
        .dext     (dext_q),
        .size_log2(sz_q),
        .seq_idx  (cnt_q[IDX_W-1:0]),
        .rev_idx  (rev_idx),
        .run_base (run_q),
        .addr     (out_addr),
        .elem_idx (out_idx)
    );

    // Decode of the operation inputs, used only when start is accepted.
    always_comb begin
        base_term = base_zero ? '0 : base_in;
        dext_in   = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
        mode_in   = addr_mode_e'(mode);
        if (mode_in == AM_ESTRIDE && disp == '0)
            mode_in = AM_UNIT;
        accept    = start && !busy_q;
        bad_len   = (mode_in == AM_BITREV) && !len_zero && !len_pow2;
    end

    // Handshake and end-of-vector detection.
    always_comb begin
        last_elem = (cnt_q + CNT_W'(1)) == len_q;
        fire      = busy_q && out_ready && !trunc;
        run_next  = run_q + dext_q;
    end

    // Sequencer state: capture, element stepping, truncation and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            lg_q    <= '0;
            mode_q  <= AM_UNIT;
            sz_q    <= '0;
            base_q  <= '0;
            dext_q  <= '0;
            run_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            fbase_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                cnt_q  <= '0;
                len_q  <= eff_len;
                lg_q   <= len_lg2;
                mode_q <= mode_in;
                sz_q   <= size_log2;
                base_q <= base_term;
                dext_q <= dext_in;
                run_q  <= base_term;
                err_q  <= bad_len;
                if (len_zero || bad_len) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    fbase_q <= base_term;
                end else begin
                    busy_q  <= 1'b1;
                end
            end else if (busy_q && trunc) begin
                busy_q  <= 1'b0;
                done_q  <= 1'b1;
                fbase_q <= (mode_q == AM_POSTINC) ? run_q : base_q;
            end else if (fire) begin
                cnt_q <= cnt_q + CNT_W'(1);
                if (mode_q == AM_POSTINC)
                    run_q <= run_next;
                if (last_elem) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    fbase_q <= (mode_q == AM_POSTINC) ? run_next : base_q;
                end
            end
        end
    end

    // Output wiring.
    always_comb begin
        out_valid  = busy_q;
        done       = done_q;
        err        = err_q;
        final_base = fbase_q;
    end

    // ---------------- assertions ----------------

    // R8: a stalled element stays presented and unchanged.
    a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !trunc |=>
            out_valid && $stable(out_addr) && $stable(out_idx));

    // R4: consecutive post-increment addresses differ by the displacement.
    a_r4_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last_elem && mode_q == AM_POSTINC |=>
            out_addr == $past(out_addr) + $past(dext_q));

    // R2: consecutive unit-stride addresses differ by the element size.
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last_elem && mode_q == AM_UNIT |=>
            out_addr == $past(out_addr) + (AW'(1) << $past(sz_q)));

    // R9: done never coincides with a presented element.
    a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R10: an error means no element is presented.
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);

    // R6: the element counter never reaches the configured maximum while busy.
    a_r6_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cnt_q < CNT_W'(MAX_LEN));

    // R5: a reversed index stays inside the effective length.
    a_r5_rev_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && mode_q == AM_BITREV |-> CNT_W'(out_idx) < len_q);

    // R12: a start while busy leaves the captured operation untouched.
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && start |=> $stable(base_q) && $stable(mode_q) && $stable(len_q));

    // R7: truncation ends the vector with done on the next cycle.
    a_r7_trunc_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && trunc |=> done && !out_valid);

endmodule

// File: tb/vagu_seq_tb.sv
`timescale 1ns/1ps
module vagu_seq_tb;

    typedef struct packed {
        logic [2:0]  idx;
        logic [63:0] addr;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] base_in = '0;
    logic        base_zero = 1'b0;
    logic [15:0] disp = '0;
    logic [1:0]  size_log2 = '0;
    logic [1:0]  mode = '0;
    logic [7:0]  req_len = '0;
    logic        trunc = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [2:0]  out_idx;
    logic [63:0] out_addr;
    logic        done;
    logic [63:0] final_base;
    logic        err;

    vagu_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_in(base_in),
        .base_zero(base_zero), .disp(disp), .size_log2(size_log2),
        .mode(mode), .req_len(req_len), .trunc(trunc), .out_ready(out_ready),
        .out_valid(out_valid), .out_idx(out_idx), .out_addr(out_addr),
        .done(done), .final_base(final_base), .err(err)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    int    ops_done = 0;
    int    issued = 0;
    int    trunc_at = -1;
    int    start_cyc = 0;
    bit    rdy_all = 1'b1;
    bit    quick_end = 1'b0;
    bit    finished = 1'b0;
    bit    stall_seen = 1'b0;
    item_t stall_item;
    logic [63:0] exp_final = '0;
    logic        exp_err = 1'b0;
    string       cur_tag = "";
    logic [7:0]  lfsr = 8'hA5;
    item_t       expq[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] rev_bits(input int v, input int nb);
        logic [2:0] r = '0;
        for (int b = 0; b < nb; b++)
            if (v[b]) r[nb-1-b] = 1'b1;
        return r;
    endfunction

    // Driver: computes the expected stream, then issues the operation.
    task automatic run_op(input string tag, input logic [63:0] b, input bit bz,
                          input logic [15:0] d, input logic [1:0] sz,
                          input logic [1:0] md, input logic [7:0] rq,
                          input int tr_at, input bit all_rdy, input bit poke);
        logic [63:0] bt;
        logic [63:0] dx;
        logic [1:0]  em;
        int          eff;
        int          lg;
        int          n;
        int          nis;
        int          seen;
        bit          pow2;
        item_t       it;
        bt   = bz ? 64'd0 : b;
        dx   = {{48{d[15]}}, d};
        em   = (md == 2'd1 && d == 16'd0) ? 2'd0 : md;
        eff  = (rq > 8) ? 8 : int'(rq);
        pow2 = (eff != 0) && ((eff & (eff - 1)) == 0);
        lg   = 0;
        for (int i = 0; i < 4; i++) if (eff[i]) lg = i;
        exp_err   = (em == 2'd3) && eff != 0 && !pow2;
        n         = (exp_err || eff == 0) ? 0 : eff;
        nis       = (tr_at >= 0 && tr_at < n) ? tr_at : n;
        quick_end = (n == 0);
        for (int i = 0; i < nis; i++) begin
            it.idx = 3'(i);
            case (em)
                2'd0: it.addr = bt + dx + (64'(i) << sz);
                2'd1: it.addr = bt + dx * 64'(i);
                2'd2: it.addr = bt + dx * 64'(i);
                default: begin
                    it.idx  = rev_bits(i, lg);
                    it.addr = bt + dx + (64'(it.idx) << sz);
                end
            endcase
            expq.push_back(it);
        end
        exp_final = (em == 2'd2) ? bt + dx * 64'(nis) : bt;
        cur_tag   = tag;
        trunc_at  = tr_at;
        rdy_all   = all_rdy;
        issued    = 0;
        seen      = ops_done;
        @(negedge clk);
        base_in = b; base_zero = bz; disp = d; size_log2 = sz;
        mode = md; req_len = rq; start = 1'b1; start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            base_in = 64'hDEAD_BEEF_0000_0000; mode = 2'd3; req_len = 8'd3;
            disp = 16'h7777; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (ops_done != seen);
    endtask

    // Monitor: drives ready/trunc, then pops and compares accepted elements.
    always @(negedge clk) begin
        item_t e;
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = rdy_all ? 1'b1 : (lfsr[0] | lfsr[2]);
        trunc = out_valid && trunc_at >= 0 && issued == trunc_at;
        #1;
        if (stall_seen) begin
            // R8: stalled element still presented and unchanged
            check(out_valid && out_idx == stall_item.idx && out_addr == stall_item.addr,
                  "R8 hold", out_addr, stall_item.addr);
        end
        stall_seen = out_valid && !out_ready && !trunc;
        stall_item.idx  = out_idx;
        stall_item.addr = out_addr;
        if (out_valid && out_ready && !trunc) begin
            if (expq.size() == 0) begin
                check(1'b0, {cur_tag, " extra element"}, out_addr, 64'd0);
            end else begin
                e = expq.pop_front();
                check(out_idx == e.idx, {cur_tag, " index"}, 64'(out_idx), 64'(e.idx));
                check(out_addr == e.addr, {cur_tag, " address"}, out_addr, e.addr);
            end
            issued++;
        end
        if (done && rst_n) begin
            // R9: final base valid with done; all expected elements seen
            check(final_base == exp_final, {cur_tag, " R9 final_base"}, final_base, exp_final);
            check(expq.size() == 0, {cur_tag, " R9 missing elements"}, 64'(expq.size()), 64'd0);
            // R10: error flag matches length legality
            check(err == exp_err, {cur_tag, " R10 err"}, 64'(err), 64'(exp_err));
            if (quick_end) // R11: done the cycle after start
                check(cyc - start_cyc == 1, {cur_tag, " R11 latency"},
                      64'(cyc - start_cyc), 64'd1);
            expq.delete();
            ops_done++;
        end
    end

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && !done && !err, "reset state", {61'd0, out_valid, done, err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 unit stride, word size, all sizes
        run_op("R2 unit w4", 64'h10, 0, 16'd8, 2'd2, 2'd0, 8'd2, -1, 1, 0);
        run_op("R2 unit d8 stall", 64'h1000, 0, 16'hFFF0, 2'd3, 2'd0, 8'd8, -1, 0, 0);
        run_op("R2 unit b1", 64'h200, 0, 16'd3, 2'd0, 2'd0, 8'd5, -1, 0, 0);
        run_op("R2 unit h2", 64'h300, 0, 16'd0, 2'd1, 2'd0, 8'd3, -1, 1, 0);
        // R1 zero base flag ignores base_in
        run_op("R1 base zero", 64'hFFFF_0000_1234_5678, 1, 16'd64, 2'd2, 2'd0, 8'd4, -1, 1, 0);
        run_op("R1 base zero post", 64'h5555, 1, 16'd4, 2'd0, 2'd2, 8'd3, -1, 1, 0);
        // R3 element stride, positive and negative, and zero displacement
        run_op("R3 estride", 64'h10, 0, 16'd24, 2'd2, 2'd1, 8'd2, -1, 1, 0);
        run_op("R3 estride neg", 64'h800, 0, 16'hFFF8, 2'd3, 2'd1, 8'd6, -1, 0, 0);
        run_op("R3 estride zero disp", 64'h40, 0, 16'd0, 2'd2, 2'd1, 8'd4, -1, 1, 0);
        // R4 post-increment
        run_op("R4 postinc", 64'h10, 0, 16'd24, 2'd2, 2'd2, 8'd2, -1, 1, 0);
        run_op("R4 postinc stall", 64'h100, 0, 16'hFFFC, 2'd0, 2'd2, 8'd7, -1, 0, 0);
        // R5 bit-reversed order 0,2,1,3 and 8 elements
        run_op("R5 bitrev 4", 64'h10, 0, 16'd4, 2'd2, 2'd3, 8'd4, -1, 1, 0);
        run_op("R5 bitrev 8", 64'h2000, 0, 16'd0, 2'd3, 2'd3, 8'd8, -1, 0, 0);
        run_op("R5 bitrev 1", 64'h80, 0, 16'd2, 2'd1, 2'd3, 8'd1, -1, 1, 0);
        // R6 clamp to MAX_LEN
        run_op("R6 clamp", 64'h0, 0, 16'd1, 2'd0, 2'd0, 8'd200, -1, 1, 0);
        run_op("R6 clamp bitrev", 64'h0, 0, 16'd0, 2'd2, 2'd3, 8'd20, -1, 1, 0);
        // R7 truncation
        run_op("R7 trunc post", 64'h100, 0, 16'd24, 2'd2, 2'd2, 8'd8, 2, 0, 0);
        run_op("R7 trunc first", 64'h100, 0, 16'd8, 2'd2, 2'd0, 8'd4, 0, 1, 0);
        run_op("R7 trunc bitrev", 64'h0, 0, 16'd0, 2'd2, 2'd3, 8'd8, 5, 1, 0);
        // R10 bad bit-reversed length, then cleared by the next start
        run_op("R10 bitrev len3", 64'h300, 0, 16'd4, 2'd2, 2'd3, 8'd3, -1, 1, 0);
        run_op("R10 err cleared", 64'h300, 0, 16'd4, 2'd2, 2'd0, 8'd1, -1, 1, 0);
        // R11 zero length
        run_op("R11 zero len", 64'hABCD, 0, 16'd4, 2'd2, 2'd2, 8'd0, -1, 1, 0);
        // R12 start while busy is ignored
        run_op("R12 poke unit", 64'h1000, 0, 16'd16, 2'd3, 2'd0, 8'd6, -1, 1, 1);
        run_op("R12 poke post", 64'h1000, 0, 16'd16, 2'd3, 2'd2, 8'd4, -1, 0, 1);
        // R13 wraparound
        run_op("R13 wrap unit", 64'hFFFF_FFFF_FFFF_FFF0, 0, 16'd8, 2'd3, 2'd0, 8'd3, -1, 1, 0);
        run_op("R13 wrap post", 64'h8, 0, 16'hFFF8, 2'd3, 2'd2, 8'd4, -1, 1, 0);

        repeat (3) @(negedge clk);
        finish_sim();
    end

endmodule